// File: doc/BRIEF.md
# Selection Timeout Timer

This block times how long an initiator or target waits for the other side to answer a selection or reselection on a SCSI bus. Software programs a timeout value in time units and a clock conversion factor. A start pulse arms the timer and captures both settings. A prescaler divides the input clock into time units. A unit counter counts those units up to the programmed value. When the count is reached, a single-cycle `timeout_o` pulse goes to the interrupt logic, where it shares the disconnect/timeout interrupt bit.

One time unit is `CYC_PER_UNIT` × CCF input clocks. In silicon `CYC_PER_UNIT` is 7682. A register value of zero stands for 256 units. A conversion factor below the legal minimum of 2 is raised to 2. A cancel pulse, sent for example when the far device responds, stops the timer silently. Another start pulse while the timer runs begins the wait again from zero.

Top module: `selto_timer`

## Requirements
- R1: After reset, `timeout_o` is 0 and the timer is idle.
- R2: After a start pulse sampled at clock edge E0, `timeout_o` is first 1 immediately after edge E0+N, where N = `CYC_PER_UNIT` × CCFe × U. CCFe is the effective conversion factor and U is the effective unit count.
- R3: A `tmo_units_i` value of 0 gives U = 256. Any other value v gives U = v.
- R4: A `ccf_i` value below 2 (0 or 1) gives CCFe = 2. Values of 2 and above are used as given.
- R5: `timeout_o` stays high for exactly one clock cycle per expiry.
- R6: A cancel pulse while running stops the timer, and no pulse follows. When cancel and start are both high in the same cycle, cancel wins and the timer stays idle.
- R7: A start pulse while running restarts the full count from zero. The earlier expiry never appears.
- R8: `tmo_units_i` and `ccf_i` are sampled only at the start pulse. Changing them later has no effect on the running count.
- R9: Without a start pulse, `timeout_o` never rises.
- R10: A cancel pulse while idle has no effect. A later start still produces the R2 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_units_i | input | TMO_W | Timeout in time units; 0 means 256 |
| ccf_i | input | CCF_W | Clock conversion factor |
| start_i | input | 1 | Arm or restart pulse |
| cancel_i | input | 1 | Stop pulse, no timeout reported |
| timeout_o | output | 1 | One-cycle expiry pulse |

## Verification
The bench builds the timer with `CYC_PER_UNIT` = 3 and keeps the 8-bit timeout register and 3-bit conversion factor at full width. This makes a unit only a few clocks long. The sweep can then cover every conversion factor, including the clamped values 0 and 1, against unit counts of 1, 2, 3, 255 and the zero-means-256 case, and count each expiry edge exactly. The same small unit lets the bench place cancel, restart and mid-run setting changes at chosen cycles.

// File: rtl/selto_pkg.sv
package selto_pkg;
  localparam int DEF_CYC_PER_UNIT = 7682;
  localparam int DEF_TMO_W        = 8;
  localparam int DEF_CCF_W        = 3;
  localparam int DEF_CCF_MIN      = 2;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} selto_state_e;
endpackage

// File: rtl/selto_decode.sv
module selto_decode #(
  parameter int TMO_W   = 8,
  parameter int CCF_W   = 3,
  parameter int CCF_MIN = 2,
  localparam int UNIT_W = TMO_W + 1
) (
  input  logic [TMO_W-1:0]  units_i,
  input  logic [CCF_W-1:0]  ccf_i,
  output logic [UNIT_W-1:0] limit_o,
  output logic [CCF_W-1:0]  ccf_eff_o
);
  // zero selects the full 2**TMO_W units
  always_comb begin
    if (units_i == '0) limit_o = {1'b1, {TMO_W{1'b0}}};
    else               limit_o = {1'b0, units_i};
  end

  always_comb begin
    if (ccf_i < CCF_W'(CCF_MIN)) ccf_eff_o = CCF_W'(CCF_MIN);
    else                         ccf_eff_o = ccf_i;
  end
endmodule

// File: rtl/selto_prescaler.sv
module selto_prescaler #(
  parameter int CYC_PER_UNIT = 7682,
  parameter int CCF_W        = 3,
  localparam int PRE_W       = (CYC_PER_UNIT > 1) ? $clog2(CYC_PER_UNIT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [CCF_W-1:0] ccf_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CCF_W-1:0] rep_q;
  logic             pre_wrap;
  logic             rep_wrap;

  assign pre_wrap = (pre_q == PRE_W'(CYC_PER_UNIT - 1));
  assign rep_wrap = (rep_q == ccf_i - CCF_W'(1));
  assign tick_o   = run_i && pre_wrap && rep_wrap;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      pre_q <= '0;
      rep_q <= '0;
    end else if (run_i) begin
      if (pre_wrap) begin
        pre_q <= '0;
        rep_q <= rep_wrap ? '0 : rep_q + CCF_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  assert_pre_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    pre_q <= PRE_W'(CYC_PER_UNIT - 1));
  assert_rep_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (rep_q < ccf_i));
endmodule

// File: rtl/selto_unit_counter.sv
module selto_unit_counter #(
  parameter int TMO_W   = 8,
  localparam int UNIT_W = TMO_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [UNIT_W-1:0] limit_i,
  output logic              last_o
);
  logic [UNIT_W-1:0] cnt_q;

  assign last_o = tick_i && (cnt_q == limit_i - UNIT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear_i)  cnt_q <= '0;
    else if (tick_i)     cnt_q <= last_o ? '0 : cnt_q + UNIT_W'(1);
  end

  assert_unit_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt_q < limit_i));
  assert_tick_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
    tick_i |-> run_i);
endmodule

// File: rtl/selto_timer.sv
module selto_timer
  import selto_pkg::*;
#(
  parameter int CYC_PER_UNIT = DEF_CYC_PER_UNIT,
  parameter int TMO_W        = DEF_TMO_W,
  parameter int CCF_W        = DEF_CCF_W,
  parameter int CCF_MIN      = DEF_CCF_MIN,
  localparam int UNIT_W      = TMO_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMO_W-1:0] tmo_units_i,
  input  logic [CCF_W-1:0] ccf_i,
  input  logic             start_i,
  input  logic             cancel_i,
  output logic             timeout_o
);
  selto_state_e      state_q;
  logic [CCF_W-1:0]  ccf_q;
  logic [UNIT_W-1:0] limit_q;
  logic              timeout_q;
  logic [CCF_W-1:0]  dec_ccf;
  logic [UNIT_W-1:0] dec_limit;
  logic              running;
  logic              restart;
  logic              tick;
  logic              last;

  assign running = (state_q == ST_RUN);
  assign restart = start_i || cancel_i;

  selto_decode #(.TMO_W(TMO_W), .CCF_W(CCF_W), .CCF_MIN(CCF_MIN)) u_decode (
    .units_i  (tmo_units_i),
    .ccf_i    (ccf_i),
    .limit_o  (dec_limit),
    .ccf_eff_o(dec_ccf)
  );

  selto_prescaler #(.CYC_PER_UNIT(CYC_PER_UNIT), .CCF_W(CCF_W)) u_prescaler (
    .clk    (clk),
    .rst    (rst),
    .clear_i(restart),
    .run_i  (running),
    .ccf_i  (ccf_q),
    .tick_o (tick)
  );

  selto_unit_counter #(.TMO_W(TMO_W)) u_units (
    .clk    (clk),
    .rst    (rst),
    .clear_i(restart),
    .run_i  (running),
    .tick_i (tick),
    .limit_i(limit_q),
    .last_o (last)
  );

  // priority: cancel, then start, then expiry
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ccf_q     <= CCF_W'(CCF_MIN);
      limit_q   <= UNIT_W'(1);
      timeout_q <= 1'b0;
    end else begin
      timeout_q <= last && !start_i && !cancel_i;
      if (cancel_i) begin
        state_q <= ST_IDLE;
      end else if (start_i) begin
        state_q <= ST_RUN;
        ccf_q   <= dec_ccf;
        limit_q <= dec_limit;
      end else if (last) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign timeout_o = timeout_q;

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);
  assert_cancel_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    cancel_i |=> !timeout_o);
  assert_start_arms_R7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !cancel_i) |=> (running && !timeout_o));
  assert_pulse_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> $past(running));
endmodule

// File: tb/selto_timer_bench.sv
module selto_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 3;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] units = 8'd1;
  logic [2:0] ccf = 3'd2;
  logic       start = 1'b0;
  logic       cancel = 1'b0;
  logic       timeout;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selto_timer #(.CYC_PER_UNIT(CYC)) u_selto_timer (
    .clk(clk), .rst(rst), .tmo_units_i(units), .ccf_i(ccf),
    .start_i(start), .cancel_i(cancel), .timeout_o(timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_n(input int c, input int u);
    int ce = (c < 2) ? 2 : c;
    int ue = (u == 0) ? 256 : u;
    return CYC * ce * ue;
  endfunction

  // one-cycle start; returns at the negedge after edge E0
  task automatic fire_start(input int c, input int u);
    ccf = 3'(c); units = 8'(u); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // count edges until the pulse; 0 if none within lim
  task automatic find_pulse(input int lim, output int at);
    at = 0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (timeout) begin at = k; break; end
    end
  endtask

  task automatic measure(input int c, input int u, input string req);
    int at;
    int n = expect_n(c, u);
    fire_start(c, u);
    find_pulse(n + 4, at);
    check(at == n, req, at, n);
    @(negedge clk);
    check(timeout == 1'b0, "R5", timeout, 0);
  endtask

  task automatic quiet(input int len, input string req);
    int at;
    find_pulse(len, at);
    check(at == 0, req, at, 0);
  endtask

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int at;
    int n;
    repeat (3) @(negedge clk);
    check(timeout == 1'b0, "R1", timeout, 0);
    rst = 1'b0;
    @(negedge clk);
    check(timeout == 1'b0, "R1", timeout, 0);
    quiet(60, "R9");

    // sweep: all CCF codes (R4 clamp on 0,1) against unit counts (R3 zero)
    for (int c = 0; c < 8; c++) begin
      measure(c, 1, "R2");
      measure(c, 2, "R2");
      measure(c, 3, (c < 2) ? "R4" : "R2");
      measure(c, 255, "R2");
      measure(c, 0, "R3");
    end

    // R6: cancel mid-run, then nothing
    fire_start(3, 4);
    repeat (10) @(negedge clk);
    cancel = 1'b1; @(negedge clk); cancel = 1'b0;
    quiet(expect_n(3, 4) + 10, "R6");

    // R6: start and cancel together
    ccf = 3'd2; units = 8'd2; start = 1'b1; cancel = 1'b1;
    @(negedge clk);
    start = 1'b0; cancel = 1'b0;
    quiet(expect_n(2, 2) + 10, "R6");

    // R10: cancel while idle, then a normal run
    cancel = 1'b1; @(negedge clk); cancel = 1'b0;
    quiet(5, "R10");
    measure(2, 5, "R10");

    // R7: restart before expiry
    fire_start(2, 3);
    repeat (expect_n(2, 3) - 2) @(negedge clk);
    n = expect_n(2, 3);
    fire_start(2, 3);
    find_pulse(n + 4, at);
    check(at == n, "R7", at, n);

    // R7: restart on the very cycle of expiry
    fire_start(2, 2);
    repeat (expect_n(2, 2) - 1) @(negedge clk);
    fire_start(4, 1);
    n = expect_n(4, 1);
    find_pulse(n + 4, at);
    check(at == n, "R7", at, n);

    // R8: settings changed after start are ignored
    fire_start(2, 3);
    ccf = 3'd7; units = 8'd1;
    n = expect_n(2, 3);
    find_pulse(n + 4, at);
    check(at == n, "R8", at, n);

    quiet(40, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule